// File: doc/BRIEF.md
# Conditional Relative Jump Unit

This block resolves one relative-jump instruction word per cycle. When an instruction is presented with its valid strobe, the unit recognises whether it carries the jump tag in its top three bits. For a jump, it tests a 3-bit condition field against the negative, zero, carry and overflow flags. It then produces the address of the next instruction, which is either the branch target or the sequential successor. The branch target is the incremented instruction address plus twice a signed 10-bit word offset.

A front end uses the unit by presenting the instruction word, its address and the current flag values together with a valid strobe. One cycle later the unit presents registered results: a taken indication, a jump-detect indication and the next program counter. The unit only reads the flags and drives no flag value back. Any word without the jump tag passes through with the sequential successor as its next address.

Top module: `cond_jump_unit`

## Requirements
- R1: One cycle after a valid instruction, `jmp_seen` is 1 exactly when bits [15:13] of the word equal 3'b001, and 0 otherwise.
- R2: For a jump, `br_taken` follows the condition in bits [12:10]: 3'b000 when Z=0, 3'b001 when Z=1, 3'b010 when C=0, 3'b011 when C=1, 3'b100 when N=1, 3'b101 when N equals V, 3'b110 when N differs from V, 3'b111 always.
- R3: A taken jump sets `pc_next` to (address + 2) + 2 × the sign-extended offset in bits [9:0], with the sum taken modulo 2^16.
- R4: A jump whose condition fails gives `br_taken`=0 and `pc_next` = address + 2.
- R5: A word that is not a jump gives `br_taken`=0 and `pc_next` = address + 2, modulo 2^16, whatever the flags are.
- R6: Bit 0 of the instruction address is treated as 0, so bit 0 of `pc_next` is always 0.
- R7: Results appear one clock after `op_valid`. While `op_valid` is low, the next cycle shows `br_taken`=0 and `jmp_seen`=0, and `pc_next` keeps its value.
- R8: While `rst_n` is low, all outputs are 0.
- R9: Offset extremes are handled: 10'h1FF adds 1022 bytes and 10'h200 subtracts 1024 bytes, including wraparound below address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction word and address are valid |
| op_word | input | 16 | Instruction word |
| op_addr | input | 16 | Address of the instruction word |
| flg_n | input | 1 | Negative flag |
| flg_z | input | 1 | Zero flag |
| flg_c | input | 1 | Carry flag |
| flg_v | input | 1 | Overflow flag |
| br_taken | output | 1 | Registered: jump taken |
| jmp_seen | output | 1 | Registered: word was a jump |
| pc_next | output | 16 | Registered: next program counter |

## Verification
The hardest cases to reach are the negative-offset wraparound below address zero and the two signed comparisons. The signed comparisons need N and V set independently of each other. The stimulus table places a minimum-offset unconditional jump at address 0, and it drives all four N/V combinations that split the greater-or-equal and less-than codes. Directed steps then drop the valid strobe while a jump word sits on the bus, and they assert reset after results are present. These steps show that nothing leaks through when no instruction is valid.

// File: rtl/jmp_pkg.sv
package jmp_pkg;
    parameter int WORD_W = 16;
    parameter int ADDR_W = 16;
    parameter int OFFS_W = 10;
    parameter int COND_W = 3;
    parameter int TAG_W  = 3;
    parameter logic [TAG_W-1:0] JMP_TAG = 3'b001;

    localparam int COND_LSB = OFFS_W;
    localparam int TAG_LSB  = WORD_W - TAG_W;

    typedef enum logic [COND_W-1:0] {
        CC_ZCLR = 3'b000,
        CC_ZSET = 3'b001,
        CC_CCLR = 3'b010,
        CC_CSET = 3'b011,
        CC_NEG  = 3'b100,
        CC_GE   = 3'b101,
        CC_LT   = 3'b110,
        CC_ANY  = 3'b111
    } cond_e;

    typedef struct packed {
        logic              taken;
        logic              seen;
        logic [ADDR_W-1:0] pc;
    } res_t;
endpackage

// File: rtl/jmp_cond_eval.sv
module jmp_cond_eval
    import jmp_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic              fn,
    input  logic              fz,
    input  logic              fc,
    input  logic              fv,
    output logic              hit
);
    always_comb begin
        unique case (cond_e'(cond))
            CC_ZCLR: hit = ~fz;
            CC_ZSET: hit = fz;
            CC_CCLR: hit = ~fc;
            CC_CSET: hit = fc;
            CC_NEG:  hit = fn;
            CC_GE:   hit = ~(fn ^ fv);
            CC_LT:   hit = fn ^ fv;
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/jmp_target_calc.sv
module jmp_target_calc #(
    parameter int AW = 16,
    parameter int OW = 10
) (
    input  logic [AW-1:0] addr,
    input  logic [OW-1:0] offs,
    output logic [AW-1:0] seq_pc,
    output logic [AW-1:0] tgt_pc
);
    localparam int EXT_W = AW - OW - 1;

    logic [AW-1:0] base_even;
    logic [AW-1:0] byte_offs;

    always_comb begin
        base_even = {addr[AW-1:1], 1'b0};
        seq_pc    = base_even + AW'(2);
        byte_offs = {{EXT_W{offs[OW-1]}}, offs, 1'b0};
        tgt_pc    = seq_pc + byte_offs;
    end
endmodule

// File: rtl/cond_jump_unit.sv
module cond_jump_unit
    import jmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [WORD_W-1:0] op_word,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              flg_n,
    input  logic              flg_z,
    input  logic              flg_c,
    input  logic              flg_v,
    output logic              br_taken,
    output logic              jmp_seen,
    output logic [ADDR_W-1:0] pc_next
);
    logic              is_jmp;
    logic              cond_hit;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] tgt_pc;
    res_t              st_d, st_q;

    assign is_jmp = (op_word[WORD_W-1:TAG_LSB] == JMP_TAG);

    jmp_cond_eval u_cond (
        .cond (op_word[COND_LSB +: COND_W]),
        .fn   (flg_n),
        .fz   (flg_z),
        .fc   (flg_c),
        .fv   (flg_v),
        .hit  (cond_hit)
    );

    jmp_target_calc #(.AW(ADDR_W), .OW(OFFS_W)) u_tgt (
        .addr   (op_addr),
        .offs   (op_word[OFFS_W-1:0]),
        .seq_pc (seq_pc),
        .tgt_pc (tgt_pc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        st_d.seen  = 1'b0;
        if (op_valid) begin
            st_d.seen  = is_jmp;
            st_d.taken = is_jmp & cond_hit;
            st_d.pc    = (is_jmp & cond_hit) ? tgt_pc : seq_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign br_taken = st_q.taken;
    assign jmp_seen = st_q.seen;
    assign pc_next  = st_q.pc;

    // R2 R5
    taken_needs_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> jmp_seen);

    // R6
    even_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_next[0] == 1'b0);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!br_taken && !jmp_seen && $stable(pc_next)));

    // R5
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_word[WORD_W-1:TAG_LSB] != JMP_TAG) |=>
        (!br_taken && pc_next == ADDR_W'({$past(op_addr[ADDR_W-1:1]), 1'b0} + ADDR_W'(2))));

    // R2
    always_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_word[WORD_W-1:COND_LSB] == {JMP_TAG, 3'b111}) |=> br_taken);

    // R1
    seen_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_word[WORD_W-1:TAG_LSB] == JMP_TAG) |=> jmp_seen);
endmodule

// File: tb/cond_jump_unit_test.sv
`timescale 1ns/1ps
module cond_jump_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [15:0] op_word = '0;
    logic [15:0] op_addr = '0;
    logic        flg_n = 1'b0, flg_z = 1'b0, flg_c = 1'b0, flg_v = 1'b0;
    logic        br_taken, jmp_seen;
    logic [15:0] pc_next;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    cond_jump_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
        .op_addr(op_addr), .flg_n(flg_n), .flg_z(flg_z), .flg_c(flg_c),
        .flg_v(flg_v), .br_taken(br_taken), .jmp_seen(jmp_seen), .pc_next(pc_next)
    );

    // {word, addr, nzcv, exp_taken, exp_pc, exp_seen}
    localparam int NV = 20;
    localparam logic [53:0] VEC [NV] = '{
        {16'h2FE4, 16'h8000, 4'b0010, 1'b1, 16'h7FCA, 1'b1}, // R2 R3 carry set, -28 words
        {16'h2FE4, 16'h8000, 4'b0000, 1'b0, 16'h8002, 1'b1}, // R4 carry clear
        {16'h2005, 16'h1000, 4'b0000, 1'b1, 16'h100C, 1'b1}, // R2 Z=0 code
        {16'h2005, 16'h1000, 4'b0100, 1'b0, 16'h1002, 1'b1}, // R4
        {16'h2405, 16'h1000, 4'b0100, 1'b1, 16'h100C, 1'b1}, // R2 Z=1 code
        {16'h2803, 16'h2000, 4'b0000, 1'b1, 16'h2008, 1'b1}, // R2 C=0 code
        {16'h2803, 16'h2000, 4'b0010, 1'b0, 16'h2002, 1'b1}, // R4
        {16'h3010, 16'h4000, 4'b1000, 1'b1, 16'h4022, 1'b1}, // R2 negative
        {16'h3010, 16'h4000, 4'b0000, 1'b0, 16'h4002, 1'b1}, // R4
        {16'h3401, 16'h0100, 4'b1001, 1'b1, 16'h0104, 1'b1}, // R2 N==V
        {16'h3401, 16'h0100, 4'b1000, 1'b0, 16'h0102, 1'b1}, // R4 N!=V
        {16'h3801, 16'h0100, 4'b0001, 1'b1, 16'h0104, 1'b1}, // R2 N!=V
        {16'h3801, 16'h0100, 4'b0000, 1'b0, 16'h0102, 1'b1}, // R4 N==V
        {16'h3DFF, 16'h0000, 4'b0000, 1'b1, 16'h0400, 1'b1}, // R9 max offset
        {16'h3E00, 16'h0400, 4'b0000, 1'b1, 16'h0002, 1'b1}, // R9 min offset
        {16'h3E00, 16'h0000, 4'b1111, 1'b1, 16'hFC02, 1'b1}, // R9 wrap below zero
        {16'h3C01, 16'h1001, 4'b0000, 1'b1, 16'h1004, 1'b1}, // R6 odd address
        {16'h4504, 16'h1234, 4'b1111, 1'b0, 16'h1236, 1'b0}, // R1 R5 non-jump
        {16'h1005, 16'hFFFE, 4'b0010, 1'b0, 16'h0000, 1'b0}, // R5 wrap
        {16'h4031, 16'h0011, 4'b0000, 1'b0, 16'h0012, 1'b0}  // R6 non-jump odd
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<5000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 taken", {15'b0, br_taken}, 16'h0);
        chk("R8 seen", {15'b0, jmp_seen}, 16'h0);
        chk("R8 pc", pc_next, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 idle after reset keeps zero
        chk("R7 idle pc", pc_next, 16'h0);

        for (int i = 0; i < NV; i++) begin
            op_valid = 1'b1;
            op_word  = VEC[i][53:38];
            op_addr  = VEC[i][37:22];
            {flg_n, flg_z, flg_c, flg_v} = VEC[i][21:18];
            @(negedge clk);
            chk($sformatf("R2/R4/R5 taken vec%0d", i), {15'b0, br_taken}, {15'b0, VEC[i][17]});
            chk($sformatf("R3/R6/R9 pc vec%0d", i), pc_next, VEC[i][16:1]);
            chk($sformatf("R1 seen vec%0d", i), {15'b0, jmp_seen}, {15'b0, VEC[i][0]});
        end

        // R7: strobe low with an unconditional jump on the bus
        held = pc_next;
        op_valid = 1'b0;
        op_word  = 16'h3C10;
        op_addr  = 16'h5000;
        @(negedge clk);
        chk("R7 taken idle", {15'b0, br_taken}, 16'h0);
        chk("R7 seen idle", {15'b0, jmp_seen}, 16'h0);
        chk("R7 pc hold", pc_next, held);
        @(negedge clk);
        chk("R7 pc hold2", pc_next, held);

        // R7: one-cycle latency, then release
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R7 latency pc", pc_next, 16'h5022);
        chk("R7 latency taken", {15'b0, br_taken}, 16'h1);
        @(negedge clk);
        chk("R7 drop taken", {15'b0, br_taken}, 16'h0);
        chk("R7 keep pc", pc_next, 16'h5022);

        // R8: reset after results present
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 pc after rst", pc_next, 16'h0);
        chk("R8 seen after rst", {15'b0, jmp_seen}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule